// File: doc/BRIEF.md
# Byte-Order Address Munging Unit

This unit sits between the load/store pipeline of a processor and a 64-bit data bus. It gives software a switchable byte order without a byte-reordering network. In little-endian mode it leaves the data lanes alone and flips the low three bits of the effective address with a constant that depends on the operand size. An 8-byte operand is therefore never altered, and software that only uses naturally sized operands sees a consistent little-endian memory. Accesses tagged as hashed translation-table lookups are always handled big-endian, whatever the mode.

Each request is registered and comes out one clock later as a bus access: address, byte-lane enables and lane-placed write data. A request whose byte range would cross an 8-byte boundary instead comes out as a one-cycle alignment fault. Read data from the bus is turned into a right-justified register value under the parameters of the access that was last issued. An optional fixed byte reversal of every 64-bit word on the bus side, selected by a configuration input, models a board wired with the opposite byte order.

Two mode bits are kept: the current order, and the order the privileged context runs in. A trap-entry pulse copies the second bit into the first.

Top module: `byte_order_unit`

## Requirements
- R1: After reset the current mode bit and the privileged mode bit are both 0 (big-endian), `modeLe` reads 0, and `busValid` and `alignFault` are 0.
- R2: When `msrWe` is high at a clock edge, the current bit takes `msrLeIn` and the privileged bit takes `msrOsLeIn`. A request presented in that same cycle still uses the previous current bit, and `modeLe` shows the new value from the next cycle on.
- R3: A `trapEnter` pulse with `msrWe` low copies the privileged bit into the current bit. When both are high, `msrWe` wins.
- R4: For a data access in little-endian mode, the low 3 bits of `busAddr` are the effective address bits XOR 3'b111 (1 byte), 3'b110 (2 bytes), 3'b100 (4 bytes) or 3'b000 (8 bytes). In big-endian mode they pass unchanged. The upper address bits always pass unchanged. The access appears on the bus outputs one cycle after the request.
- R5: A request with `reqKind` = 2'd1 (translation-table lookup) is never munged: its address passes unchanged in either mode. All other kind codes are data accesses.
- R6: `reqSize` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes and 4 = a 128-bit vector beat. A vector beat follows the 8-byte rule: XOR constant 0 and all eight lanes.
- R7: Bus lane k covers bits [63-8k : 56-8k] and is enabled by `busLanes[k]`. An N-byte operand at munged offset m enables lanes m to m+N-1. The write data puts the operand's most significant byte in lane m. Only the low N bytes of `reqWdata` are used, and other lanes carry 0.
- R8: `loadData` is the N bytes in lanes m to m+N-1 of `busRdata`, right-justified and zero-extended. It uses the offset, size and swap setting of the most recently issued access, even after the mode bits change.
- R9: If m+N exceeds 8, the cycle after the request has `alignFault` high and `busValid` low. A correct request gives `busValid` high and `alignFault` low. The two are never high together.
- R10: With `busSwapEn` high when a request is issued, the placed write data is byte-reversed across all 8 lanes, and read data is byte-reversed before extraction. This applies in either mode.
- R11: A 64-bit value stored at an aligned address in one mode and loaded back from the same address in the other mode returns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Effective byte address |
| reqSize | input | 3 | Operand size code |
| reqKind | input | 2 | Access-type tag, 1 = translation-table lookup |
| reqWrite | input | 1 | Request is a store |
| reqWdata | input | 64 | Right-justified store operand |
| msrWe | input | 1 | Load both mode bits |
| msrLeIn | input | 1 | New current mode bit, 1 = little-endian |
| msrOsLeIn | input | 1 | New privileged-context mode bit |
| trapEnter | input | 1 | Enter privileged context |
| busSwapEn | input | 1 | Enable bus-side 8-byte reversal |
| busRdata | input | 64 | Read data from the bus |
| busValid | output | 1 | Bus access issued |
| busWrite | output | 1 | Issued access is a store |
| busAddr | output | 32 | Munged bus byte address |
| busLanes | output | 8 | Byte-lane enables |
| busWdata | output | 64 | Lane-placed store data |
| alignFault | output | 1 | Boundary-crossing request rejected |
| loadData | output | 64 | Right-justified load result |
| modeLe | output | 1 | Current mode bit |

## Verification
Bus address, lanes, write data, `busValid` and `alignFault` come from a single register stage, so they are due one edge after the request. The bench drives each request on a falling edge and reads the results on the next falling edge. `loadData` is combinational from `busRdata` and the held issue state, so it is checked in that same window and again after later mode writes. A mode write is visible on `modeLe` after one edge, and it affects only requests presented after that edge. The bench checks this by presenting a request in the cycle of the write itself.

// File: rtl/bo_pkg.sv
package bo_pkg;
  // access-type tag that is always handled big-endian
  localparam logic [1:0] KIND_TABLE = 2'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;   // register the access and put it on the bus
    logic fault;   // reject the access
  } strobe_t;
endpackage

// File: rtl/bo_byte_swap.sv
module bo_byte_swap #(
  parameter int DATA_W = 64
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] revd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign revd[8*g +: 8] = din[8*(LANES-1-g) +: 8];
  end

  assign dout = en ? revd : din;
endmodule

// File: rtl/bo_ctrl.sv
module bo_ctrl import bo_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       crossing,
  input  logic       msrWe,
  input  logic       msrLeIn,
  input  logic       msrOsLeIn,
  input  logic       trapEnter,
  output strobe_t    st,
  output logic       effLe,
  output logic       modeLe,
  output logic       busValid,
  output logic       alignFault
);
  logic curLe, osLe;
  logic validQ, faultQ;

  always_comb begin
    effLe    = curLe && (reqKind != KIND_TABLE);
    st.issue = reqValid && !crossing;
    st.fault = reqValid && crossing;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLe  <= 1'b0;
      osLe   <= 1'b0;
      validQ <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      if (msrWe) begin
        curLe <= msrLeIn;
        osLe  <= msrOsLeIn;
      end else if (trapEnter) begin
        curLe <= osLe;
      end
      validQ <= st.issue;
      faultQ <= st.fault;
    end
  end

  assign modeLe     = curLe;
  assign busValid   = validQ;
  assign alignFault = faultQ;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && alignFault));

  p_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && crossing) |=> (alignFault && !busValid));

  p_msr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    msrWe |=> (modeLe == $past(msrLeIn)));

  p_trap_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trapEnter && !msrWe) |=> (modeLe == $past(osLe)));
endmodule

// File: rtl/bo_datapath.sv
module bo_datapath import bo_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic                  effLe,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2:0]            reqSize,
  input  logic                  reqWrite,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic                  busSwapEn,
  input  logic [DATA_W-1:0]     busRdata,
  output logic                  crossing,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W/8-1:0]   busLanes,
  output logic [DATA_W-1:0]     busWdata,
  output logic                  busWrite,
  output logic [DATA_W-1:0]     loadData
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;
  localparam int SH_W  = CNT_W + 3;

  logic [CNT_W-1:0]  sizeLog, nBytes, endLane, shiftBytes;
  logic [OFF_W-1:0]  mungeVal, laneOff;
  logic [SH_W-1:0]   shiftAmt;
  logic [LANES-1:0]  laneMask;
  logic [DATA_W-1:0] opMask, placed, placedSw;

  always_comb begin
    if (int'(reqSize) > OFF_W) sizeLog = CNT_W'(OFF_W);
    else                       sizeLog = CNT_W'(reqSize);
    nBytes     = CNT_W'(1) << sizeLog;
    mungeVal   = effLe ? (OFF_W'(LANES-1) & ~OFF_W'(nBytes - CNT_W'(1))) : '0;
    laneOff    = reqAddr[OFF_W-1:0] ^ mungeVal;
    endLane    = {1'b0, laneOff} + nBytes;
    crossing   = endLane > CNT_W'(LANES);
    shiftBytes = CNT_W'(LANES) - endLane;
    shiftAmt   = {shiftBytes, 3'b000};
    for (int k = 0; k < LANES; k++) begin
      laneMask[k]     = (CNT_W'(k) >= {1'b0, laneOff}) && (CNT_W'(k) < endLane);
      opMask[8*k +: 8] = (CNT_W'(k) < nBytes) ? 8'hFF : 8'h00;
    end
    placed = (reqWdata & opMask) << shiftAmt;
  end

  bo_byte_swap #(.DATA_W(DATA_W)) uWrSwap (
    .en(busSwapEn), .din(placed), .dout(placedSw)
  );

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  lanesQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ, issSwap;
  logic [SH_W-1:0]   issShift;
  logic [CNT_W-1:0]  issBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      lanesQ   <= '0;
      wdataQ   <= '0;
      writeQ   <= 1'b0;
      issSwap  <= 1'b0;
      issShift <= '0;
      issBytes <= '0;
    end else if (st.issue) begin
      addrQ    <= {reqAddr[ADDR_W-1:OFF_W], laneOff};
      lanesQ   <= laneMask;
      wdataQ   <= placedSw;
      writeQ   <= reqWrite;
      issSwap  <= busSwapEn;
      issShift <= shiftAmt;
      issBytes <= nBytes;
    end
  end

  logic [DATA_W-1:0] rdSw, issMask;

  bo_byte_swap #(.DATA_W(DATA_W)) uRdSwap (
    .en(issSwap), .din(busRdata), .dout(rdSw)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++)
      issMask[8*k +: 8] = (CNT_W'(k) < issBytes) ? 8'hFF : 8'h00;
    loadData = (rdSw >> issShift) & issMask;
  end

  assign busAddr  = addrQ;
  assign busLanes = lanesQ;
  assign busWdata = wdataQ;
  assign busWrite = writeQ;

  p_addr_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && !effLe) |=> (busAddr == $past(reqAddr)));

  p_full_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && reqSize >= 3'd3) |=>
      (busLanes == '1 && busAddr[OFF_W-1:0] == $past(reqAddr[OFF_W-1:0])));

  p_lane_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.issue |=> ($countones(busLanes) == int'($past(nBytes))));
endmodule

// File: rtl/byte_order_unit.sv
module byte_order_unit import bo_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2:0]          reqSize,
  input  logic [1:0]          reqKind,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                msrWe,
  input  logic                msrLeIn,
  input  logic                msrOsLeIn,
  input  logic                trapEnter,
  input  logic                busSwapEn,
  input  logic [DATA_W-1:0]   busRdata,
  output logic                busValid,
  output logic                busWrite,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busLanes,
  output logic [DATA_W-1:0]   busWdata,
  output logic                alignFault,
  output logic [DATA_W-1:0]   loadData,
  output logic                modeLe
);
  strobe_t st;
  logic    effLe, crossing;

  bo_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .crossing(crossing), .msrWe(msrWe), .msrLeIn(msrLeIn),
    .msrOsLeIn(msrOsLeIn), .trapEnter(trapEnter), .st(st), .effLe(effLe),
    .modeLe(modeLe), .busValid(busValid), .alignFault(alignFault)
  );

  bo_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .effLe(effLe), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busSwapEn(busSwapEn), .busRdata(busRdata), .crossing(crossing),
    .busAddr(busAddr), .busLanes(busLanes), .busWdata(busWdata),
    .busWrite(busWrite), .loadData(loadData)
  );
endmodule

// File: tb/tb_byte_order_unit.sv
module tb_byte_order_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, msrWe, msrLeIn, msrOsLeIn, trapEnter, busSwapEn;
  logic [31:0] reqAddr;
  logic [2:0]  reqSize;
  logic [1:0]  reqKind;
  logic [63:0] reqWdata, busRdata;
  logic        busValid, busWrite, alignFault, modeLe;
  logic [31:0] busAddr;
  logic [7:0]  busLanes;
  logic [63:0] busWdata, loadData;

  always #10 clk = ~clk;

  byte_order_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .msrWe(msrWe), .msrLeIn(msrLeIn),
    .msrOsLeIn(msrOsLeIn), .trapEnter(trapEnter), .busSwapEn(busSwapEn),
    .busRdata(busRdata), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busLanes(busLanes), .busWdata(busWdata),
    .alignFault(alignFault), .loadData(loadData), .modeLe(modeLe)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rev8(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic int sizeBytes(input int sz);
    return (sz >= 3) ? 8 : (1 << sz);
  endfunction

  function automatic logic [63:0] byteMask(input int n);
    return (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  task automatic present(input logic [31:0] a, input int sz, input logic [1:0] kind,
                         input bit wr, input logic [63:0] wd, input logic [63:0] rd,
                         input bit sw);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = a;
    reqSize   = 3'(sz);
    reqKind   = kind;
    reqWrite  = wr;
    reqWdata  = wd;
    busRdata  = rd;
    busSwapEn = sw;
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  task automatic setMsr(input bit le, input bit osLe);
    @(negedge clk);
    msrWe = 1'b1; msrLeIn = le; msrOsLeIn = osLe;
    @(negedge clk);
    msrWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] saved;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; msrWe = 1'b0; msrLeIn = 1'b0;
    msrOsLeIn = 1'b0; trapEnter = 1'b0; busSwapEn = 1'b0; reqAddr = '0;
    reqSize = '0; reqKind = '0; reqWdata = '0; busRdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(modeLe == 1'b0, "R1 modeLe", 64'(modeLe), 64'd0);
    chk(busValid == 1'b0, "R1 busValid", 64'(busValid), 64'd0);
    chk(alignFault == 1'b0, "R1 alignFault", 64'(alignFault), 64'd0);
    present(32'h0000_1000, 0, 2'd0, 1'b0, 64'd0, 64'd0, 1'b0);
    chk(busAddr == 32'h0000_1000, "R1 big-endian after reset", 64'(busAddr), 64'h1000);

    // R2: a request in the same cycle as the mode write uses the old mode
    @(negedge clk);
    msrWe = 1'b1; msrLeIn = 1'b1; msrOsLeIn = 1'b0;
    reqValid = 1'b1; reqAddr = 32'h0000_2000; reqSize = 3'd0; reqKind = 2'd0;
    reqWrite = 1'b0; busSwapEn = 1'b0;
    @(negedge clk);
    msrWe = 1'b0; reqValid = 1'b0;
    chk(busAddr == 32'h0000_2000, "R2 same-cycle old mode", 64'(busAddr), 64'h2000);
    chk(modeLe == 1'b1, "R2 modeLe new", 64'(modeLe), 64'd1);
    present(32'h0000_2000, 0, 2'd0, 1'b0, 64'd0, 64'd0, 1'b0);
    chk(busAddr == 32'h0000_2007, "R2 next access new mode", 64'(busAddr), 64'h2007);

    // R3: trap entry copies the privileged bit
    setMsr(1'b0, 1'b1);
    chk(modeLe == 1'b0, "R3 before trap", 64'(modeLe), 64'd0);
    @(negedge clk); trapEnter = 1'b1;
    @(negedge clk); trapEnter = 1'b0;
    chk(modeLe == 1'b1, "R3 after trap", 64'(modeLe), 64'd1);
    // R3: mode write wins over a simultaneous trap
    @(negedge clk); trapEnter = 1'b1; msrWe = 1'b1; msrLeIn = 1'b0; msrOsLeIn = 1'b1;
    @(negedge clk); trapEnter = 1'b0; msrWe = 1'b0;
    chk(modeLe == 1'b0, "R3 write beats trap", 64'(modeLe), 64'd0);

    // Sweep: mode x kind x size x offset x swap x direction (R4 R5 R6 R7 R8 R9 R10)
    for (int le = 0; le < 2; le++) begin
      setMsr(1'(le), 1'b0);
      chk(modeLe == 1'(le), "R2 mode set", 64'(modeLe), 64'(le));
      for (int kind = 0; kind < 2; kind++)
        for (int sz = 0; sz < 5; sz++)
          for (int o = 0; o < 8; o++)
            for (int sw = 0; sw < 2; sw++)
              for (int wr = 0; wr < 2; wr++) begin
                int nb, c, m, sh;
                bit effLe, fault;
                logic [31:0] a;
                logic [63:0] wd, rd, expW, expL;
                string tag;
                nb    = sizeBytes(sz);
                effLe = (le == 1) && (kind != 1);
                c     = effLe ? (7 & ~(nb - 1)) : 0;
                m     = o ^ c;
                fault = (m + nb) > 8;
                a     = 32'hA5C3_1F80 + 32'(o);
                wd    = 64'h0123_4567_89AB_CDEF ^ {56'd0, 8'(o * 16 + sz)};
                rd    = 64'hF0E1_D2C3_B4A5_9687 + {48'd0, 16'(sz * 8 + o)};
                tag   = (kind == 1) ? "R5" : ((sz == 4) ? "R6" : "R4");
                present(a, sz, 2'(kind), 1'(wr), wd, rd, 1'(sw));
                chk(alignFault == fault, "R9 fault flag", 64'(alignFault), 64'(fault));
                chk(busValid == !fault, "R9 valid flag", 64'(busValid), 64'(!fault));
                if (!fault) begin
                  sh = 8 * (8 - m - nb);
                  chk(busAddr == {a[31:3], 3'(m)}, tag, 64'(busAddr), 64'({a[31:3], 3'(m)}));
                  chk(busLanes == 8'(((1 << nb) - 1) << m), "R7 lanes",
                      64'(busLanes), 64'(((1 << nb) - 1) << m));
                  if (wr == 1) begin
                    expW = (wd & byteMask(nb)) << sh;
                    if (sw == 1) expW = rev8(expW);
                    chk(busWdata == expW, (sw == 1) ? "R10 write swap" : "R7 write data",
                        busWdata, expW);
                    chk(busWrite == 1'b1, "R7 write flag", 64'(busWrite), 64'd1);
                  end else begin
                    expL = ((sw == 1) ? rev8(rd) : rd) >> sh;
                    expL = expL & byteMask(nb);
                    chk(loadData == expL, (sw == 1) ? "R10 read swap" : "R8 load data",
                        loadData, expL);
                  end
                end
              end
    end

    // R8: load result keeps the issued mode after a mode change
    setMsr(1'b1, 1'b0);
    present(32'h0000_3000, 0, 2'd0, 1'b0, 64'd0, 64'h1122_3344_5566_7788, 1'b0);
    chk(loadData == 64'h88, "R8 LE byte lane 7", loadData, 64'h88);
    setMsr(1'b0, 1'b0);
    chk(loadData == 64'h88, "R8 held after mode change", loadData, 64'h88);

    // R11: 64-bit round trip across modes
    present(32'h0000_4008, 3, 2'd0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 1'b0);
    saved = busWdata;
    chk(busAddr == 32'h0000_4008, "R11 store address", 64'(busAddr), 64'h4008);
    setMsr(1'b1, 1'b0);
    present(32'h0000_4008, 3, 2'd0, 1'b0, 64'd0, saved, 1'b0);
    chk(busAddr == 32'h0000_4008, "R11 load address", 64'(busAddr), 64'h4008);
    chk(loadData == 64'hDEAD_BEEF_0BAD_F00D, "R11 round trip", loadData,
        64'hDEAD_BEEF_0BAD_F00D);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule